// File: doc/BRIEF.md
# Multicart PRG Bank Mapper

This block is the cartridge-side address mapper of a multi-game cartridge for an 8-bit console. It watches the CPU bus. Writes to the ROM half of the address space load two small bank registers. Reads produce the upper PRG ROM address lines (A18 down to A13) and an active-low chip enable for each of two PRG ROM chips. The first register chooses how each game sees its program ROM:

- a single 16 KB bank mirrored into both CPU halves;
- one 32 KB bank;
- a switchable 16 KB bank at $8000 with a fixed last bank at $C000.

The same register selects one of four 128 KB outer regions, picks which ROM chip answers, sets nametable mirroring and gates CHR-RAM writes.

A fixed 8 KB ROM window at $6000-$7FFF always shows the second 8 KB of the first ROM chip. The menu program runs from this window, so it stays reachable whatever a game has written. A write with CPU address bit 13 set locks both registers until the next power-up. A console reset does not unlock them, so the selected game survives the reset button.

All outputs are combinational functions of the bus inputs and the register contents. The registers capture on the rising clock edge while the one-cycle write strobe is high.

Top module: `multicart_mapper`

## Requirements
- R1: A write cycle with ROM-select active and CPU A14=0 (address $8000-$BFFF) stores data bits 7..3 into the configuration register.
- R2: A write cycle with ROM-select active and CPU A14=1 (address $C000-$FFFF) stores data bits 2..0 as the 3-bit inner bank. Data bits 7..3 of that write are ignored.
- R3: During a ROM-select access, prg_a[5:4] (PRG A18..A17) equal configuration data bits 4..3 (the outer bank).
- R4: Mode code 00 (data bits 6..5): both CPU halves map to the 16 KB bank {outer, inner}. prg_a[5:1] is that bank and prg_a[0] follows CPU A13.
- R5: Mode code 01: the 16 KB bank is {outer, inner[2:1], CPU A14}, so inner bit 0 has no effect.
- R6: Mode codes 10 and 11: $8000-$BFFF maps to {outer, inner} and $C000-$FFFF maps to {outer, 111}.
- R7: Reads with ROM-select active enable the second chip (prg2_ce_n=0) when the mode code is 11, and the first chip (prg1_ce_n=0) otherwise. At most one chip enable is ever low.
- R8: A read at $6000-$7FFF (ROM-select inactive, A15..A13=011) drives prg_a=000001 with prg1_ce_n=0, whatever the register contents are.
- R9: A register write with CPU A13=1 sets a lock. From then on, neither register accepts writes until power-up reset.
- R10: por_n low clears both registers and the lock. con_rst_n has no effect on them.
- R11: The mirroring code {data bit 7, data bit 6} sets ciram_a10: 00 gives ppu_a10, 10 gives ppu_a11, and 01 or 11 gives 1.
- R12: chr_wr_en is 1 when configuration data bit 7 is 0, and 0 when it is 1.
- R13: Chip enables assert only on read cycles (cpu_rnw=1). Writes drive both enables high.
- R14: When ROM-select is inactive and the address is outside $6000-$7FFF, both chip enables are high and prg_a is 000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock on which register writes are captured |
| por_n | input | 1 | Active-low power-on reset, asynchronous clear of registers and lock |
| con_rst_n | input | 1 | Active-low console reset, ignored by the register state |
| wr_stb | input | 1 | One-cycle strobe marking the data phase of a CPU bus cycle |
| cpu_a | input | 3 | CPU address bits 15..13 |
| cpu_d | input | 8 | CPU data byte |
| cpu_rnw | input | 1 | CPU read (1) / write (0) |
| romsel_n | input | 1 | Active-low ROM-select, low for $8000-$FFFF |
| ppu_a11 | input | 1 | PPU address bit 11 |
| ppu_a10 | input | 1 | PPU address bit 10 |
| prg_a | output | 6 | PRG ROM address lines A18..A13 |
| prg1_ce_n | output | 1 | Active-low enable of the first PRG ROM |
| prg2_ce_n | output | 1 | Active-low enable of the second PRG ROM |
| chr_wr_en | output | 1 | CHR-RAM write permitted |
| ciram_a10 | output | 1 | Nametable RAM address bit 10 |

## Verification
The hardest state to reach is the locked register pair after a console reset. It needs a specific write address (A13 set on a $8000-$BFFF write), then later writes that must be refused, then a console reset pulse, and finally a power-up pulse that must release everything. The bench walks that exact sequence, reading the bank outputs after each step. It then writes once more to show that the lock has cleared. The vector table covers every mode code at both CPU halves, in both chips, with nonzero outer banks. This exposes swaps between inner bit 0 and A14 as well as the fixed last bank.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
  localparam int OUTER_W   = 2;
  localparam int INNER_W   = 3;
  localparam int CFG_W     = 5;
  localparam int BANK16_W  = OUTER_W + INNER_W;
  localparam int PA_W      = BANK16_W + 1;
  localparam int NUM_CHIPS = 2;
  localparam int CHIP_W    = $clog2(NUM_CHIPS);
  localparam logic [PA_W-1:0] WIN_BANK8 = PA_W'(1);

  typedef enum logic [1:0] {
    MODE_SINGLE16 = 2'b00,
    MODE_WHOLE32  = 2'b01,
    MODE_SWITCH_A = 2'b10,
    MODE_SWITCH_B = 2'b11
  } prg_mode_e;

  typedef struct packed {
    logic                chr_wp;
    logic [1:0]          mirror;
    prg_mode_e           mode;
    logic [OUTER_W-1:0]  outer;
  } cfg_t;

  // Stored field holds CPU data bits 7..3; bit 7 and bit 6 are shared.
  function automatic cfg_t unpack_cfg(input logic [CFG_W-1:0] f);
    cfg_t c;
    c.chr_wp = f[4];
    c.mirror = f[4:3];
    c.mode   = prg_mode_e'(f[3:2]);
    c.outer  = f[1:0];
    return c;
  endfunction

  function automatic logic [BANK16_W-1:0] pick_bank16(
      input prg_mode_e m, input logic [OUTER_W-1:0] o,
      input logic [INNER_W-1:0] i, input logic a14);
    logic [BANK16_W-1:0] b;
    case (m)
      MODE_SINGLE16: b = {o, i};
      MODE_WHOLE32:  b = {o, i[INNER_W-1:1], a14};
      default:       b = a14 ? {o, {INNER_W{1'b1}}} : {o, i};
    endcase
    return b;
  endfunction

  function automatic logic [CHIP_W-1:0] pick_chip(input prg_mode_e m);
    return (m == MODE_SWITCH_B) ? CHIP_W'(1) : CHIP_W'(0);
  endfunction

  function automatic logic nt_line(input logic [1:0] mir, input logic a11, input logic a10);
    logic r;
    if (mir[0])      r = 1'b1;
    else if (mir[1]) r = a11;
    else             r = a10;
    return r;
  endfunction
endpackage

// File: rtl/mcm_regs.sv
module mcm_regs
  import mcm_pkg::*;
(
  input  logic               clk,
  input  logic               por_n,
  input  logic               con_rst_n,
  input  logic               wr_stb,
  input  logic               cpu_rnw,
  input  logic               romsel_n,
  input  logic               cpu_a14,
  input  logic               cpu_a13,
  input  logic [7:0]         cpu_d,
  output logic [CFG_W-1:0]   cfg_q,
  output logic [INNER_W-1:0] inner_q,
  output logic               lock_q
);
  logic wr_hit, wr_cfg, wr_inner;

  assign wr_hit   = wr_stb && !cpu_rnw && !romsel_n && !lock_q;
  assign wr_cfg   = wr_hit && !cpu_a14;
  assign wr_inner = wr_hit &&  cpu_a14;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cfg_q   <= '0;
      inner_q <= '0;
      lock_q  <= 1'b0;
    end else begin
      if (wr_cfg) begin
        cfg_q <= cpu_d[7:8-CFG_W];
        if (cpu_a13) lock_q <= 1'b1;
      end
      if (wr_inner) inner_q <= cpu_d[INNER_W-1:0];
    end
  end

  a_r1_cfg_capture: assert property (@(posedge clk) disable iff (!por_n)
    wr_cfg |=> cfg_q == $past(cpu_d[7:8-CFG_W]))
    else $error("R1 config capture");

  a_r2_inner_capture: assert property (@(posedge clk) disable iff (!por_n)
    wr_inner |=> inner_q == $past(cpu_d[INNER_W-1:0]))
    else $error("R2 inner capture");

  a_r9_lock_freezes: assert property (@(posedge clk) disable iff (!por_n)
    lock_q |=> lock_q && $stable(cfg_q) && $stable(inner_q))
    else $error("R9 lock");

  a_r10_console_reset_inert: assert property (@(posedge clk) disable iff (!por_n)
    (!con_rst_n && !(wr_stb && !cpu_rnw && !romsel_n))
      |=> $stable(cfg_q) && $stable(inner_q) && $stable(lock_q))
    else $error("R10 console reset");
endmodule

// File: rtl/mcm_prg.sv
module mcm_prg
  import mcm_pkg::*;
(
  input  logic                 arm,
  input  cfg_t                 cfg,
  input  logic [INNER_W-1:0]   inner,
  input  logic [2:0]           cpu_a,
  input  logic                 cpu_rnw,
  input  logic                 romsel_n,
  output logic [PA_W-1:0]      prg_a,
  output logic [NUM_CHIPS-1:0] chip_ce_n
);
  logic                in_rom, in_win;
  logic [BANK16_W-1:0] bank16;
  logic [CHIP_W-1:0]   chip;

  assign in_rom = !romsel_n;
  assign in_win = romsel_n && (cpu_a == 3'b011);
  assign bank16 = pick_bank16(cfg.mode, cfg.outer, inner, cpu_a[1]);
  assign chip   = pick_chip(cfg.mode);

  always_comb begin
    if (in_rom)      prg_a = {bank16, cpu_a[0]};
    else if (in_win) prg_a = WIN_BANK8;
    else             prg_a = '0;
  end

  for (genvar k = 0; k < NUM_CHIPS; k++) begin : g_ce
    assign chip_ce_n[k] = !(cpu_rnw &&
                            ((in_rom && chip == CHIP_W'(k)) || (in_win && k == 0)));
  end

  always_comb begin
    if (arm) begin
      a_r7_one_chip: assert ($onehot0(~chip_ce_n)) else $error("R7 two chips");
      a_r13_no_ce_on_write: assert (cpu_rnw || (&chip_ce_n)) else $error("R13 write ce");
      a_r8_window: assert (!(romsel_n && cpu_a == 3'b011 && cpu_rnw)
                           || (!chip_ce_n[0] && prg_a == PA_W'(1)))
        else $error("R8 window");
      a_r14_idle: assert (!romsel_n || cpu_a == 3'b011
                          || ((&chip_ce_n) && prg_a == '0))
        else $error("R14 idle");
    end
  end
endmodule

// File: rtl/mcm_video.sv
module mcm_video
  import mcm_pkg::*;
(
  input  logic       arm,
  input  cfg_t       cfg,
  input  logic       ppu_a11,
  input  logic       ppu_a10,
  output logic       ciram_a10,
  output logic       chr_wr_en
);
  assign ciram_a10 = nt_line(cfg.mirror, ppu_a11, ppu_a10);
  assign chr_wr_en = !cfg.chr_wp;

  always_comb begin
    if (arm) begin
      a_r11_single_screen: assert (!(cfg.mirror[0]) || ciram_a10) else $error("R11 single");
    end
  end
endmodule

// File: rtl/multicart_mapper.sv
module multicart_mapper
  import mcm_pkg::*;
(
  input  logic            clk,
  input  logic            por_n,
  input  logic            con_rst_n,
  input  logic            wr_stb,
  input  logic [2:0]      cpu_a,
  input  logic [7:0]      cpu_d,
  input  logic            cpu_rnw,
  input  logic            romsel_n,
  input  logic            ppu_a11,
  input  logic            ppu_a10,
  output logic [PA_W-1:0] prg_a,
  output logic            prg1_ce_n,
  output logic            prg2_ce_n,
  output logic            chr_wr_en,
  output logic            ciram_a10
);
  logic [CFG_W-1:0]     cfg_q;
  logic [INNER_W-1:0]   inner_q;
  logic                 lock_q;
  logic [NUM_CHIPS-1:0] chip_ce_n;
  cfg_t                 cfg;

  assign cfg = unpack_cfg(cfg_q);

  mcm_regs u_regs (
    .clk(clk), .por_n(por_n), .con_rst_n(con_rst_n), .wr_stb(wr_stb),
    .cpu_rnw(cpu_rnw), .romsel_n(romsel_n), .cpu_a14(cpu_a[1]),
    .cpu_a13(cpu_a[0]), .cpu_d(cpu_d), .cfg_q(cfg_q), .inner_q(inner_q),
    .lock_q(lock_q)
  );

  mcm_prg u_prg (
    .arm(por_n), .cfg(cfg), .inner(inner_q), .cpu_a(cpu_a),
    .cpu_rnw(cpu_rnw), .romsel_n(romsel_n), .prg_a(prg_a),
    .chip_ce_n(chip_ce_n)
  );

  mcm_video u_video (
    .arm(por_n), .cfg(cfg), .ppu_a11(ppu_a11), .ppu_a10(ppu_a10),
    .ciram_a10(ciram_a10), .chr_wr_en(chr_wr_en)
  );

  assign prg1_ce_n = chip_ce_n[0];
  assign prg2_ce_n = chip_ce_n[1];
endmodule

// File: tb/multicart_mapper_bench.sv
module multicart_mapper_bench;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       con_rst_n = 1'b1;
  logic       wr_stb = 1'b0;
  logic [2:0] cpu_a = 3'b010;
  logic [7:0] cpu_d = 8'h00;
  logic       cpu_rnw = 1'b1;
  logic       romsel_n = 1'b1;
  logic       ppu_a11 = 1'b0;
  logic       ppu_a10 = 1'b0;
  logic [5:0] prg_a;
  logic       prg1_ce_n, prg2_ce_n, chr_wr_en, ciram_a10;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  multicart_mapper u_multicart_mapper (
    .clk(clk), .por_n(por_n), .con_rst_n(con_rst_n), .wr_stb(wr_stb),
    .cpu_a(cpu_a), .cpu_d(cpu_d), .cpu_rnw(cpu_rnw), .romsel_n(romsel_n),
    .ppu_a11(ppu_a11), .ppu_a10(ppu_a10), .prg_a(prg_a),
    .prg1_ce_n(prg1_ce_n), .prg2_ce_n(prg2_ce_n),
    .chr_wr_en(chr_wr_en), .ciram_a10(ciram_a10)
  );

  typedef struct packed {
    logic [3:0] tag;
    logic [7:0] cfg;
    logic [2:0] inner;
    logic [2:0] ahi;
    logic [5:0] pa;
    logic       ce1;
    logic       ce2;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  8'h00, 3'd5, 3'b100, 6'b001010, 1'b0, 1'b1},  // R2, R4
    '{4'd4,  8'h00, 3'd5, 3'b110, 6'b001010, 1'b0, 1'b1},  // R4
    '{4'd3,  8'h18, 3'd2, 3'b101, 6'b110101, 1'b0, 1'b1},  // R3
    '{4'd5,  8'h20, 3'd7, 3'b100, 6'b001100, 1'b0, 1'b1},  // R5
    '{4'd5,  8'h20, 3'd7, 3'b111, 6'b001111, 1'b0, 1'b1},  // R5
    '{4'd1,  8'h48, 3'd2, 3'b100, 6'b010100, 1'b0, 1'b1},  // R1, R6
    '{4'd6,  8'h48, 3'd2, 3'b110, 6'b011110, 1'b0, 1'b1},  // R6
    '{4'd7,  8'h60, 3'd3, 3'b100, 6'b000110, 1'b1, 1'b0},  // R7
    '{4'd7,  8'h60, 3'd3, 3'b111, 6'b001111, 1'b1, 1'b0},  // R7
    '{4'd8,  8'h78, 3'd0, 3'b011, 6'b000001, 1'b0, 1'b1},  // R8
    '{4'd8,  8'h38, 3'd6, 3'b011, 6'b000001, 1'b0, 1'b1},  // R8
    '{4'd14, 8'h00, 3'd0, 3'b010, 6'b000000, 1'b1, 1'b1}   // R14
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] ahi, input logic [7:0] d);
    @(negedge clk);
    cpu_a = ahi; cpu_d = d; cpu_rnw = 1'b0; romsel_n = !ahi[2]; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; cpu_rnw = 1'b1; romsel_n = 1'b1; cpu_a = 3'b010;
  endtask

  task automatic bus_rd(input logic [2:0] ahi);
    @(negedge clk);
    cpu_a = ahi; cpu_rnw = 1'b1; romsel_n = !ahi[2];
    #1;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;

    // Reset state: all fields zero (R10)
    ppu_a10 = 1'b1; ppu_a11 = 1'b0;
    bus_rd(3'b100);
    chk("R10 reset prg_a", {2'b0, prg_a}, 8'h00);
    chk("R10 reset ce", {6'b0, prg1_ce_n, prg2_ce_n}, 8'h01);
    chk("R12 reset chr_wr_en", {7'b0, chr_wr_en}, 8'h01);
    chk("R11 reset vertical", {7'b0, ciram_a10}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      bus_wr(3'b100, VECS[i].cfg);
      bus_wr(3'b110, {5'b10101, VECS[i].inner});
      bus_rd(VECS[i].ahi);
      chk($sformatf("R%0d vec%0d prg_a", VECS[i].tag, i), {2'b0, prg_a}, {2'b0, VECS[i].pa});
      chk($sformatf("R%0d vec%0d ce", VECS[i].tag, i), {6'b0, prg1_ce_n, prg2_ce_n},
          {6'b0, VECS[i].ce1, VECS[i].ce2});
    end

    // R11 mirroring and R12 CHR gating
    bus_wr(3'b100, 8'h00);
    ppu_a11 = 1'b1; ppu_a10 = 1'b0; bus_rd(3'b010);
    chk("R11 vertical follows a10", {7'b0, ciram_a10}, 8'h00);
    bus_wr(3'b100, 8'h80);
    bus_rd(3'b010);
    chk("R11 horizontal follows a11", {7'b0, ciram_a10}, 8'h01);
    chk("R12 protect", {7'b0, chr_wr_en}, 8'h00);
    ppu_a11 = 1'b0; ppu_a10 = 1'b1; bus_rd(3'b010);
    chk("R11 horizontal a11 low", {7'b0, ciram_a10}, 8'h00);
    bus_wr(3'b100, 8'h40);
    ppu_a11 = 1'b0; ppu_a10 = 1'b0; bus_rd(3'b010);
    chk("R11 single 01", {7'b0, ciram_a10}, 8'h01);
    chk("R12 allow", {7'b0, chr_wr_en}, 8'h01);
    bus_wr(3'b100, 8'hC0);
    bus_rd(3'b010);
    chk("R11 single 11", {7'b0, ciram_a10}, 8'h01);

    // R13: write cycles never enable a chip
    @(negedge clk);
    cpu_a = 3'b100; romsel_n = 1'b0; cpu_rnw = 1'b0; #1;
    chk("R13 rom write ce", {6'b0, prg1_ce_n, prg2_ce_n}, 8'h03);
    cpu_a = 3'b011; romsel_n = 1'b1; #1;
    chk("R13 window write ce", {6'b0, prg1_ce_n, prg2_ce_n}, 8'h03);
    cpu_rnw = 1'b1;

    // R9 lock via A13, R10 console reset keeps it
    bus_wr(3'b100, 8'h00);
    bus_wr(3'b110, 8'h01);
    bus_wr(3'b101, 8'h18);
    bus_wr(3'b100, 8'h00);
    bus_wr(3'b110, 8'h07);
    bus_rd(3'b100);
    chk("R9 locked regs", {2'b0, prg_a}, 8'b00110010);
    @(negedge clk); con_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    con_rst_n = 1'b1;
    bus_wr(3'b100, 8'h00);
    bus_rd(3'b100);
    chk("R10 console reset keeps lock", {2'b0, prg_a}, 8'b00110010);
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    bus_rd(3'b100);
    chk("R10 power-up clears", {2'b0, prg_a}, 8'h00);
    bus_wr(3'b100, 8'h18);
    bus_rd(3'b100);
    chk("R9 unlocked after power-up", {2'b0, prg_a}, 8'b00110000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule